// File: doc/BRIEF.md
# Exclusive Victim Cache with Sharing-Aware Retention

This block is an outer cache level that receives lines only when the inner cache throws them out. It never allocates on a memory fill, so apart from lines kept on purpose its contents do not overlap with the inner cache. The inner cache sends it two kinds of request on one port. A victim write installs an evicted line. A lookup is sent on an inner miss and can carry the victim that the inner set must give up to make room.

A lookup that hits returns the line inward. A line whose sharing flag is clear is dropped from this level at that point. A line flagged as shared or as code stays resident, and its pseudo-LRU position is refreshed. The flag travels with the line in both directions. On a lookup miss the block asks memory for the line through a simple request/response port. It passes the returned data and the memory's code/shared indication straight to the inner cache and keeps no copy.

Replacement fills an empty way first. When no way is empty it evicts an unshared line, and it falls back to shared lines only when the whole set is shared. Tree pseudo-LRU chooses among the lines of the class being evicted. The default geometry is 32 sets of 4 ways with 64-byte lines. Addresses on every port are line addresses.

Top module: `vcache_excl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, and every lookup misses.
- R2: For an accepted lookup that misses, mem_req_valid is high for exactly one cycle, the cycle after acceptance, with mem_req_addr equal to the lookup address. req_ready stays low until the memory answers. rsp_valid follows one cycle after mem_rsp_valid with rsp_hit=0, rsp_data=mem_rsp_data and rsp_shared=mem_rsp_code. Nothing is allocated, so a repeated lookup misses again.
- R3: A victim write (req_lookup=0, req_victim=1) installs the line. A later lookup of that address gives rsp_valid the cycle after acceptance, with rsp_hit=1 and the written data and sharing flag.
- R4: A lookup hit on a line whose sharing flag is 0 removes the line, so the next lookup of that address misses.
- R5: A lookup hit on a line whose sharing flag is 1 keeps the line, so the next lookup hits again.
- R6: A victim write to an address already resident overwrites the data and flag in place and creates no second copy. After one hit on the new unshared copy, the address misses.
- R7: A request presented while req_ready is 0 is not accepted and has no effect.
- R8: A victim that needs a way takes the lowest-numbered empty way. When the set is full it evicts an unshared line, and evicts a shared line only if all lines are shared. Within the chosen class, the tree pseudo-LRU decides: for ways 0..3 the root bit selects the right pair when 1, and each pair bit selects the upper way when 1. A touch points every bit on the path away from the touched way. Hits on shared lines and victim installs count as touches.
- R9: A lookup carrying a victim applies the hit first and then the install, in the same cycle. A victim in the same set as an unshared hit line takes the way that line freed, so no other line is lost.
- R10: mem_rsp_valid is ignored when no fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_lookup | input | 1 | Request includes a lookup of req_addr |
| req_addr | input | LA_W | Lookup line address |
| req_victim | input | 1 | Request carries a victim line |
| vic_addr | input | LA_W | Victim line address |
| vic_data | input | LINE_W | Victim line data |
| vic_shared | input | 1 | Victim sharing/code flag |
| rsp_valid | output | 1 | Lookup response pulse |
| rsp_hit | output | 1 | Response came from this cache |
| rsp_shared | output | 1 | Sharing/code flag of the returned line |
| rsp_data | output | LINE_W | Returned line |
| mem_req_valid | output | 1 | Memory fetch request pulse |
| mem_req_addr | output | LA_W | Memory fetch line address |
| mem_rsp_valid | input | 1 | Memory data present |
| mem_rsp_data | input | LINE_W | Memory line data |
| mem_rsp_code | input | 1 | Memory marks the line as code/shared |

## Verification
Directed sequences fill single sets with known mixes of shared and unshared lines and then probe each address. This shows whether eviction follows the sharing class or only the pseudo-LRU order, and whether a hit line stays or leaves according to its flag. Lookups that carry a victim into the same set separate a true exchange from an install that destroys a neighbour. Repeated victim writes to one address show any duplicate copy. A long random mix over two sets and a few tags, with random memory delays, is compared cycle by cycle against a behavioural model and exercises the orderings the directed cases do not reach.

// File: rtl/vc_pkg.sv
package vc_pkg;
   typedef enum logic {
      VC_IDLE  = 1'b0,
      VC_FETCH = 1'b1
   } vc_state_e;
endpackage

// File: rtl/vc_plru_pick.sv
module vc_plru_pick #(
   parameter int WAYS = 4,
   localparam int WL = $clog2(WAYS)
) (
   input  logic [WAYS-2:0] tree,
   input  logic [WAYS-1:0] cand,
   output logic [WL-1:0]   way
);
   // Walk the tree from the root; follow a node bit unless its side holds no candidate.
   always_comb begin
      int lo, span, n;
      logic l_any, r_any, go_r;
      lo = 0;
      span = WAYS;
      n = 1;
      for (int lv = 0; lv < WL; lv++) begin
         l_any = 1'b0;
         r_any = 1'b0;
         for (int w = 0; w < WAYS; w++) begin
            if (w >= lo && w < lo + span / 2) l_any = l_any | cand[w];
            if (w >= lo + span / 2 && w < lo + span) r_any = r_any | cand[w];
         end
         go_r = tree[n-1] ? (r_any || !l_any) : (!l_any && r_any);
         if (go_r) lo = lo + span / 2;
         n = 2 * n + int'(go_r);
         span = span / 2;
      end
      way = WL'(lo);
   end

   // The chosen way must belong to the eviction class (R8).
   always_comb begin
      if (|cand) p_pick_in_class_r8: assert (cand[way]);
   end
endmodule

// File: rtl/vc_set_probe.sv
module vc_set_probe #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 21,
   localparam int WL = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            valid,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           tag,
   output logic [WAYS-1:0]            match,
   output logic                       hit,
   output logic [WL-1:0]              way
);
   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == tag);
   end

   assign hit = |match;

   always_comb begin
      way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) way = WL'(w);
      end
   end
endmodule

// File: rtl/vcache_excl.sv
module vcache_excl
   import vc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 32,
   parameter int WAYS       = 4,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int LA_W   = ADDR_W - OFF_W,
   localparam int LINE_W = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_lookup,
   input  logic [LA_W-1:0]   req_addr,
   input  logic              req_victim,
   input  logic [LA_W-1:0]   vic_addr,
   input  logic [LINE_W-1:0] vic_data,
   input  logic              vic_shared,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_shared,
   output logic [LINE_W-1:0] rsp_data,
   output logic              mem_req_valid,
   output logic [LA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [LINE_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_code
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = LA_W - IDX_W;
   localparam int WL    = $clog2(WAYS);

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || TAG_W < 1) begin : g_bad_geom
      $error("line size must be a power of two and leave tag bits");
   end

   // Storage
   logic [WAYS-1:0]              valid_q [SETS];
   logic [WAYS-1:0]              shr_q   [SETS];
   logic [WAYS-2:0]              plru_q  [SETS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
   logic [WAYS-1:0][LINE_W-1:0]  data_q  [SETS];

   vc_state_e state_q;

   function automatic logic [WAYS-2:0] touch_f(input logic [WAYS-2:0] t, input logic [WL-1:0] w);
      logic [WAYS-2:0] r;
      int n;
      r = t;
      n = 1;
      for (int lv = 0; lv < WL; lv++) begin
         r[n-1] = ~w[WL-1-lv];
         n = 2 * n + int'(w[WL-1-lv]);
      end
      return r;
   endfunction

   logic fire;
   assign req_ready = (state_q == VC_IDLE);
   assign fire      = req_valid && req_ready;

   // Lookup side
   logic [IDX_W-1:0] lk_set;
   logic [TAG_W-1:0] lk_tag;
   logic [WAYS-1:0]  lk_match;
   logic             lk_hit;
   logic [WL-1:0]    lk_way;
   logic             lk_keep;
   logic             lk_fire_hit;
   logic             lk_fire_miss;

   assign lk_set = req_addr[IDX_W-1:0];
   assign lk_tag = req_addr[LA_W-1:IDX_W];

   vc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_probe (
      .valid (valid_q[lk_set]),
      .tags  (tag_q[lk_set]),
      .tag   (lk_tag),
      .match (lk_match),
      .hit   (lk_hit),
      .way   (lk_way)
   );

   assign lk_keep      = shr_q[lk_set][lk_way];
   assign lk_fire_hit  = fire && req_lookup && lk_hit;
   assign lk_fire_miss = fire && req_lookup && !lk_hit;

   // Victim side, seen after the lookup's effect on its set
   logic [IDX_W-1:0] vc_set;
   logic [TAG_W-1:0] vc_tag;
   logic [WAYS-1:0]  mid_valid;
   logic [WAYS-2:0]  mid_plru;
   logic [WAYS-1:0]  vc_match;
   logic             vc_hit;
   logic [WL-1:0]    vc_way;
   logic [WAYS-1:0]  inv;
   logic [WL-1:0]    inv_way;
   logic [WAYS-1:0]  cand;
   logic [WL-1:0]    pick_way;
   logic [WL-1:0]    vc_dst;
   logic             vc_fire;

   assign vc_set  = vic_addr[IDX_W-1:0];
   assign vc_tag  = vic_addr[LA_W-1:IDX_W];
   assign vc_fire = fire && req_victim;

   always_comb begin
      mid_valid = valid_q[vc_set];
      mid_plru  = plru_q[vc_set];
      if (lk_fire_hit && (vc_set == lk_set)) begin
         if (lk_keep) mid_plru = touch_f(mid_plru, lk_way);
         else         mid_valid[lk_way] = 1'b0;
      end
   end

   vc_set_probe #(.WAYS(WAYS), .TAG_W(TAG_W)) u_vc_probe (
      .valid (mid_valid),
      .tags  (tag_q[vc_set]),
      .tag   (vc_tag),
      .match (vc_match),
      .hit   (vc_hit),
      .way   (vc_way)
   );

   assign inv = ~mid_valid;

   always_comb begin
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (inv[w]) inv_way = WL'(w);
      end
   end

   // Unshared lines first; all lines when the set is entirely shared.
   always_comb begin
      cand = ~shr_q[vc_set];
      if (cand == '0) cand = '1;
   end

   vc_plru_pick #(.WAYS(WAYS)) u_pick (
      .tree (mid_plru),
      .cand (cand),
      .way  (pick_way)
   );

   assign vc_dst = vc_hit ? vc_way : ((|inv) ? inv_way : pick_way);

   // State updates
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            shr_q[s]   <= '0;
            plru_q[s]  <= '0;
         end
      end else begin
         if (lk_fire_hit) begin
            if (lk_keep) plru_q[lk_set] <= touch_f(plru_q[lk_set], lk_way);
            else         valid_q[lk_set][lk_way] <= 1'b0;
         end
         if (vc_fire) begin
            valid_q[vc_set][vc_dst] <= 1'b1;
            shr_q[vc_set][vc_dst]   <= vic_shared;
            plru_q[vc_set]          <= touch_f(mid_plru, vc_dst);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (vc_fire) begin
         tag_q[vc_set][vc_dst]  <= vc_tag;
         data_q[vc_set][vc_dst] <= vic_data;
      end
   end

   // Control, fetch and response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= VC_IDLE;
         mem_req_valid <= 1'b0;
         mem_req_addr  <= '0;
         rsp_valid     <= 1'b0;
         rsp_hit       <= 1'b0;
         rsp_shared    <= 1'b0;
         rsp_data      <= '0;
      end else begin
         mem_req_valid <= 1'b0;
         rsp_valid     <= 1'b0;
         if (lk_fire_hit) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            rsp_shared <= lk_keep;
            rsp_data   <= data_q[lk_set][lk_way];
         end
         if (lk_fire_miss) begin
            state_q       <= VC_FETCH;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= req_addr;
         end
         if (state_q == VC_FETCH && mem_rsp_valid) begin
            state_q    <= VC_IDLE;
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_shared <= mem_rsp_code;
            rsp_data   <= mem_rsp_data;
         end
      end
   end

   // Assertions
   p_fetch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);
   p_fetch_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   p_miss_rsp_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> $past(mem_rsp_valid));
   p_hit_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fire_hit |=> (rsp_valid && rsp_hit));
   p_no_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match) && $onehot0(vc_match));
   p_idle_mem_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == VC_IDLE && mem_rsp_valid && !lk_fire_hit) |=> !rsp_valid);
endmodule

// File: tb/test_vcache_excl.sv
`timescale 1ns/1ps
module test_vcache_excl;
   localparam int LA_W = 26;
   localparam int LW   = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          req_valid = 0, req_lookup = 0, req_victim = 0, vic_shared = 0;
   logic [LA_W-1:0] req_addr = '0, vic_addr = '0;
   logic [LW-1:0] vic_data = '0, mem_rsp_data = '0;
   logic          mem_rsp_valid = 0, mem_rsp_code = 0;
   logic          req_ready, rsp_valid, rsp_hit, rsp_shared, mem_req_valid;
   logic [LW-1:0] rsp_data;
   logic [LA_W-1:0] mem_req_addr;

   vcache_excl i_vcache_excl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_lookup(req_lookup), .req_addr(req_addr), .req_victim(req_victim),
      .vic_addr(vic_addr), .vic_data(vic_data), .vic_shared(vic_shared),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_shared(rsp_shared),
      .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_code(mem_rsp_code)
   );

   int n_chk = 0, n_bad = 0;
   string cur_req = "R1";
   bit cmp_en = 0;
   bit done = 0;

   task automatic chk(input string req, input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [LA_W-1:0] la(input int tag, input int set);
      return {tag[20:0], set[4:0]};
   endfunction

   function automatic logic [LW-1:0] mk(input int seed);
      logic [LW-1:0] r;
      for (int i = 0; i < 16; i++) r[i*32 +: 32] = (seed * 32'h9E3779B1) ^ (i * 32'h01010101) ^ 32'h5A5A0000;
      return r;
   endfunction

   // ---------------- behavioural reference model ----------------
   logic          m_v  [32][4];
   logic          m_s  [32][4];
   logic [20:0]   m_t  [32][4];
   logic [LW-1:0] m_d  [32][4];
   logic [2:0]    m_pl [32];
   bit            m_busy;
   logic          e_ready, e_rv, e_hit, e_sh, e_mrv;
   logic [LW-1:0] e_data;
   logic [LA_W-1:0] e_maddr;

   function automatic int m_pick(input int s, input logic [3:0] c);
      bit lhas, rhas, right;
      lhas = c[0] | c[1];
      rhas = c[2] | c[3];
      if (m_pl[s][0]) right = rhas || !lhas;
      else            right = !lhas && rhas;
      if (right) begin
         if (m_pl[s][2]) return (c[3] || !c[2]) ? 3 : 2;
         return (!c[2] && c[3]) ? 3 : 2;
      end
      if (m_pl[s][1]) return (c[1] || !c[0]) ? 1 : 0;
      return (!c[0] && c[1]) ? 1 : 0;
   endfunction

   task automatic m_touch(input int s, input int w);
      case (w)
         0: begin m_pl[s][0] = 1; m_pl[s][1] = 1; end
         1: begin m_pl[s][0] = 1; m_pl[s][1] = 0; end
         2: begin m_pl[s][0] = 0; m_pl[s][2] = 1; end
         default: begin m_pl[s][0] = 0; m_pl[s][2] = 0; end
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < 32; s++) begin
            m_pl[s] = 3'b000;
            for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_s[s][w] = 0; end
         end
         m_busy = 0; e_ready = 1; e_rv = 0; e_hit = 0; e_sh = 0; e_mrv = 0;
         e_data = '0; e_maddr = '0;
      end else begin
         e_rv = 0;
         e_mrv = 0;
         if (!m_busy && req_valid) begin
            if (req_lookup) begin
               int s, hw;
               s = int'(req_addr[4:0]);
               hw = -1;
               for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == req_addr[25:5]) hw = w;
               if (hw >= 0) begin
                  e_rv = 1; e_hit = 1; e_sh = m_s[s][hw]; e_data = m_d[s][hw];
                  if (m_s[s][hw]) m_touch(s, hw);
                  else m_v[s][hw] = 0;
               end else begin
                  m_busy = 1; e_mrv = 1; e_maddr = req_addr;
               end
            end
            if (req_victim) begin
               int s, dw;
               logic [3:0] c;
               s = int'(vic_addr[4:0]);
               dw = -1;
               for (int w = 0; w < 4; w++) if (m_v[s][w] && m_t[s][w] == vic_addr[25:5]) dw = w;
               if (dw < 0) for (int w = 3; w >= 0; w--) if (!m_v[s][w]) dw = w;
               if (dw < 0) begin
                  for (int w = 0; w < 4; w++) c[w] = !m_s[s][w];
                  if (c == 4'b0000) c = 4'b1111;
                  dw = m_pick(s, c);
               end
               m_v[s][dw] = 1; m_s[s][dw] = vic_shared;
               m_t[s][dw] = vic_addr[25:5]; m_d[s][dw] = vic_data;
               m_touch(s, dw);
            end
         end else if (m_busy && mem_rsp_valid) begin
            m_busy = 0; e_rv = 1; e_hit = 0; e_sh = mem_rsp_code; e_data = mem_rsp_data;
         end
         e_ready = !m_busy;
      end
   end

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         chk(cur_req, "req_ready", LW'(req_ready), LW'(e_ready));
         chk(cur_req, "rsp_valid", LW'(rsp_valid), LW'(e_rv));
         if (e_rv) begin
            chk(cur_req, "rsp_hit", LW'(rsp_hit), LW'(e_hit));
            chk(cur_req, "rsp_shared", LW'(rsp_shared), LW'(e_sh));
            chk(cur_req, "rsp_data", rsp_data, e_data);
         end
         chk(cur_req, "mem_req_valid", LW'(mem_req_valid), LW'(e_mrv));
         if (e_mrv) chk(cur_req, "mem_req_addr", LW'(mem_req_addr), LW'(e_maddr));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic victim(input logic [LA_W-1:0] a, input logic [LW-1:0] d, input bit sh);
      @(negedge clk);
      req_valid = 1; req_lookup = 0; req_victim = 1; vic_addr = a; vic_data = d; vic_shared = sh;
      @(negedge clk);
      req_valid = 0; req_victim = 0;
   endtask

   task automatic lookup(input string req, input logic [LA_W-1:0] a, input bit has_v,
                         input logic [LA_W-1:0] va, input logic [LW-1:0] vd, input bit vs,
                         input bit code, input int dly, input int exp_hit, input logic [LW-1:0] exp_d);
      @(negedge clk);
      req_valid = 1; req_lookup = 1; req_addr = a; req_victim = has_v;
      vic_addr = va; vic_data = vd; vic_shared = vs;
      @(negedge clk);
      req_valid = 0; req_lookup = 0; req_victim = 0;
      if (!rsp_valid && mem_req_valid) begin
         for (int i = 0; i < dly; i++) @(negedge clk);
         mem_rsp_valid = 1; mem_rsp_data = mk(int'(a) + 777); mem_rsp_code = code;
         @(negedge clk);
         mem_rsp_valid = 0;
      end
      chk(req, "response present", LW'(rsp_valid), LW'(1));
      if (exp_hit >= 0) chk(req, "hit", LW'(rsp_hit), LW'(exp_hit));
      if (exp_hit == 1) chk(req, "hit data", rsp_data, exp_d);
   endtask

   task automatic lk(input string req, input logic [LA_W-1:0] a, input int exp_hit, input logic [LW-1:0] exp_d);
      lookup(req, a, 0, '0, '0, 0, 0, 1, exp_hit, exp_d);
   endtask

   task automatic finish_run;
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      cmp_en = 1;
      @(negedge clk);
      // R1: reset state
      cur_req = "R1";
      chk("R1", "req_ready", LW'(req_ready), LW'(1));
      chk("R1", "rsp_valid", LW'(rsp_valid), LW'(0));
      chk("R1", "mem_req_valid", LW'(mem_req_valid), LW'(0));
      lk("R1", la(1, 3), 0, '0);

      // R2: miss path, code flag forwarded, no allocation
      cur_req = "R2";
      lookup("R2", la(1, 3), 0, '0, '0, 0, 1, 3, 0, '0);
      chk("R2", "rsp_shared from memory", LW'(rsp_shared), LW'(1));
      chk("R2", "rsp_data from memory", rsp_data, mk(int'(la(1, 3)) + 777));
      lk("R2", la(1, 3), 0, '0);

      // R3 / R4: unshared install, hit, removal
      cur_req = "R3";
      victim(la(1, 3), mk(11), 0);
      lk("R3", la(1, 3), 1, mk(11));
      chk("R3", "rsp_shared", LW'(rsp_shared), LW'(0));
      cur_req = "R4";
      lk("R4", la(1, 3), 0, '0);

      // R5: shared line stays
      cur_req = "R5";
      victim(la(2, 3), mk(12), 1);
      lk("R5", la(2, 3), 1, mk(12));
      chk("R5", "rsp_shared", LW'(rsp_shared), LW'(1));
      lk("R5", la(2, 3), 1, mk(12));

      // R6: overwrite in place
      cur_req = "R6";
      victim(la(3, 3), mk(13), 1);
      victim(la(3, 3), mk(14), 0);
      lk("R6", la(3, 3), 1, mk(14));
      lk("R6", la(3, 3), 0, '0);

      // R8: unshared evicted before shared
      cur_req = "R8";
      victim(la(0, 7), mk(20), 1);
      victim(la(1, 7), mk(21), 0);
      victim(la(2, 7), mk(22), 1);
      victim(la(3, 7), mk(23), 0);
      victim(la(4, 7), mk(24), 0);
      lk("R8", la(1, 7), 0, '0);
      lk("R8", la(0, 7), 1, mk(20));
      lk("R8", la(2, 7), 1, mk(22));
      lk("R8", la(3, 7), 1, mk(23));
      lk("R8", la(4, 7), 1, mk(24));
      // R8: all shared, pseudo-LRU picks way 0
      victim(la(0, 9), mk(30), 1);
      victim(la(1, 9), mk(31), 1);
      victim(la(2, 9), mk(32), 1);
      victim(la(3, 9), mk(33), 1);
      victim(la(4, 9), mk(34), 1);
      lk("R8", la(0, 9), 0, '0);
      lk("R8", la(1, 9), 1, mk(31));
      lk("R8", la(4, 9), 1, mk(34));

      // R9: exchange into the freed way, no loss
      cur_req = "R9";
      victim(la(0, 11), mk(40), 0);
      victim(la(1, 11), mk(41), 0);
      victim(la(2, 11), mk(42), 0);
      victim(la(3, 11), mk(43), 0);
      lookup("R9", la(2, 11), 1, la(9, 11), mk(49), 0, 0, 1, 1, mk(42));
      lk("R9", la(0, 11), 1, mk(40));
      lk("R9", la(1, 11), 1, mk(41));
      lk("R9", la(3, 11), 1, mk(43));
      lk("R9", la(9, 11), 1, mk(49));
      lookup("R9", la(5, 13), 1, la(6, 13), mk(50), 1, 0, 2, 0, '0);
      lk("R9", la(6, 13), 1, mk(50));

      // R7: request while busy is dropped
      cur_req = "R7";
      @(negedge clk);
      req_valid = 1; req_lookup = 1; req_addr = la(1, 15); req_victim = 0;
      @(negedge clk);
      req_valid = 1; req_lookup = 0; req_victim = 1; vic_addr = la(2, 15); vic_data = mk(60); vic_shared = 1;
      chk("R7", "busy", LW'(req_ready), LW'(0));
      @(negedge clk);
      req_valid = 0; req_victim = 0;
      mem_rsp_valid = 1; mem_rsp_data = mk(61); mem_rsp_code = 0;
      @(negedge clk);
      mem_rsp_valid = 0;
      chk("R7", "fetch answered", LW'(rsp_valid), LW'(1));
      lk("R7", la(2, 15), 0, '0);

      // R10: stray memory response
      cur_req = "R10";
      @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = mk(70);
      @(negedge clk);
      mem_rsp_valid = 0;
      chk("R10", "no response", LW'(rsp_valid), LW'(0));
      @(negedge clk);
      chk("R10", "no response later", LW'(rsp_valid), LW'(0));

      // Random mix against the model (R8, R9 orderings)
      cur_req = "R8";
      for (int i = 0; i < 400; i++) begin
         logic [LA_W-1:0] a, va;
         int op;
         a  = la($urandom_range(0, 5), $urandom_range(0, 1));
         va = la($urandom_range(0, 5), $urandom_range(0, 1));
         op = $urandom_range(0, 2);
         if (op == 0) victim(va, mk(1000 + i), 1'($urandom_range(0, 1)));
         else if (op == 1 || va == a) lookup("R8", a, 0, '0, '0, 0, 1'($urandom_range(0, 1)), $urandom_range(0, 2), -1, '0);
         else lookup("R9", a, 1, va, mk(2000 + i), 1'($urandom_range(0, 1)), 0, $urandom_range(0, 2), -1, '0);
      end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule